// File: doc/BRIEF.md
# Prefix-Matching Differential Prefetch Predictor

This block predicts prefetch addresses for a repeating task. It keeps a small store of complete differential vectors. Each entry of a vector is the signed step between the address a task instance used at a given position and the address the previous instance used at that same position. While a new task runs, its own differential arrives one position at a time, starting at position 0. The block compares each arriving entry with the entry at the same position in every stored vector. Each comparison narrows a set of candidate vectors. The set is refilled with all occupied store slots whenever a task starts.

As soon as exactly one stored vector still agrees with the prefix seen so far, the block predicts the rest of the vector in one go. For every later position p, it reads the previous instance's address at p through a read port. It adds the stored entry at p to that address and offers the sum as a prefetch request under a valid/ready handshake. A task that finishes with every position filled in adds its vector to the store, unless the store already holds an identical vector. The store has eight slots and overwrites the oldest slot first.

Top module: `pfp_prefix_predictor`

## Requirements
- R1: After reset the store is empty and `pf_valid` is 0, so a task run on an empty store issues no prefetch.
- R2: At each `task_start` the candidate set is refilled with every occupied store slot. An entry arriving at position i removes every candidate whose stored entry at position i differs from it.
- R3: While two or more candidates remain, no prefetch is issued.
- R4: When an entry at position k leaves exactly one candidate and k is below the last position, the block issues requests for positions k+1 up to the last position, in ascending order. Each address equals `prev_rd_addr` read at that position (`prev_rd_idx` = p) plus the stored 16-bit entry for that position, sign-extended.
- R5: Requests move one per cycle, and a request is consumed only on a cycle where `pf_valid` and `pf_ready` are both 1. While `pf_ready` is 0, `pf_valid` stays 1 and the offered position does not change.
- R6: Once the candidate set is empty, no prefetch is issued for the rest of that task, whatever entries follow. The next `task_start` restores prediction.
- R7: `task_stop` drops every pending request: `pf_valid` is 0 in the cycle after it.
- R8: On `task_stop`, if every position of the running task's differential has been received, the vector is written into the store. Writes fill the eight slots in turn, and the ninth distinct vector overwrites the oldest one.
- R9: A completed vector identical to a vector already stored is not written, so it takes no slot.
- R10: A prediction starts at most once per task. If the prefix first becomes unique at the last position, nothing is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| task_start | input | 1 | One-cycle pulse: a new task instance begins |
| task_stop | input | 1 | One-cycle pulse: the current task instance ends |
| diff_valid | input | 1 | A differential entry is present this cycle |
| diff_idx | input | 2 | Position of the entry |
| diff_val | input | 16 | Signed differential entry |
| prev_rd_idx | output | 2 | Position whose previous-instance address is read |
| prev_rd_addr | input | 32 | Previous-instance address at `prev_rd_idx`, same cycle |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_ready | input | 1 | The consumer accepts the offered request |
| pf_addr | output | 32 | Prefetch address |

## Verification
An entry that makes the prefix unique is registered at one clock edge, and the first request is already offered after that same edge. Its address is formed combinationally from `prev_rd_addr`, with no extra register stage. Each later request follows one accepted edge after the one before it. `task_stop` clears `pf_valid` at its own edge, and a vector stored at that edge is available to a task started on the next cycle. The bench drives inputs just after a rising edge and samples outputs, including accepted requests, on the falling edge, so each check reads the value due in that cycle.

// File: rtl/pfp_pkg.sv
// Shared defaults and types for the prefix-matching prefetch predictor.
// Assumes: nothing; holds only constants and the issue-state encoding.
package pfp_pkg;
    localparam int unsigned PFP_ADDR_W  = 32;
    localparam int unsigned PFP_DIFF_W  = 16;
    localparam int unsigned PFP_VEC_LEN = 4;
    localparam int unsigned PFP_NUM_VEC = 8;

    typedef enum logic {
        ISS_IDLE = 1'b0,
        ISS_RUN  = 1'b1
    } iss_state_e;
endpackage

// File: rtl/pfp_vector_store.sv
// Vector store: NUM_VEC slots of VEC_LEN signed entries, filled round-robin.
// Gives a per-slot match mask for one (position, value) probe and one random
// read of a stored entry. Drops a write that equals an occupied slot.
// Assumes: wr_vec is stable in the cycle wr_en is high; NUM_VEC >= 2.
module pfp_vector_store #(
    parameter  int unsigned NUM_VEC = pfp_pkg::PFP_NUM_VEC,
    parameter  int unsigned VEC_LEN = pfp_pkg::PFP_VEC_LEN,
    parameter  int unsigned DIFF_W  = pfp_pkg::PFP_DIFF_W,
    localparam int unsigned IDX_W   = (VEC_LEN > 1) ? $clog2(VEC_LEN) : 1,
    localparam int unsigned SEL_W   = $clog2(NUM_VEC)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [VEC_LEN-1:0][DIFF_W-1:0]  wr_vec,
    input  logic [IDX_W-1:0]                cmp_idx,
    input  logic [DIFF_W-1:0]               cmp_val,
    output logic [NUM_VEC-1:0]              valid_o,
    output logic [NUM_VEC-1:0]              match_o,
    input  logic [SEL_W-1:0]                rd_sel,
    input  logic [IDX_W-1:0]                rd_pos,
    output logic [DIFF_W-1:0]               rd_val
);
    logic [VEC_LEN-1:0][DIFF_W-1:0] mem [NUM_VEC];
    logic [NUM_VEC-1:0]             valid;
    logic [SEL_W-1:0]               wr_ptr;
    logic                           dup;
    logic                           do_wr;

    // Detect an identical vector already held in an occupied slot.
    always_comb begin
        dup = 1'b0;
        for (int v = 0; v < NUM_VEC; v++) begin
            if (valid[v] && (mem[v] == wr_vec)) dup = 1'b1;
        end
    end

    assign do_wr = wr_en && !dup;

    // Occupancy flags and round-robin write pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid  <= '0;
            wr_ptr <= '0;
        end else if (do_wr) begin
            valid[wr_ptr] <= 1'b1;
            wr_ptr <= (wr_ptr == SEL_W'(NUM_VEC - 1)) ? '0 : wr_ptr + SEL_W'(1);
        end
    end

    // Data storage; occupancy gates every use, so no reset is needed.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_vec;
    end

    // Per-slot comparison of the probed position.
    for (genvar v = 0; v < NUM_VEC; v++) begin : g_cmp
        assign match_o[v] = valid[v] && (mem[v][cmp_idx] == cmp_val);
    end

    assign valid_o = valid;
    assign rd_val  = mem[rd_sel][rd_pos];

    // R8: occupied slots never become empty outside reset.
    p_slots_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(valid) & ~valid) == '0));

    // R9: a duplicate write leaves the slots and the pointer untouched.
    p_dup_dropped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dup) |=> (valid == $past(valid)) && $stable(wr_ptr));
endmodule

// File: rtl/pfp_match_tracker.sv
// Candidate tracker: holds the set of stored vectors that agree with the
// running prefix and signals a launch the first time it narrows to one.
// Assumes: task_start and diff_valid are never high together.
module pfp_match_tracker #(
    parameter  int unsigned NUM_VEC = pfp_pkg::PFP_NUM_VEC,
    parameter  int unsigned VEC_LEN = pfp_pkg::PFP_VEC_LEN,
    localparam int unsigned IDX_W   = (VEC_LEN > 1) ? $clog2(VEC_LEN) : 1,
    localparam int unsigned SEL_W   = $clog2(NUM_VEC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               task_start,
    input  logic               diff_valid,
    input  logic [IDX_W-1:0]   diff_idx,
    input  logic [NUM_VEC-1:0] valid_i,
    input  logic [NUM_VEC-1:0] match_i,
    output logic               launch_o,
    output logic [SEL_W-1:0]   launch_sel_o,
    output logic [IDX_W-1:0]   launch_pos_o
);
    logic [NUM_VEC-1:0] cand;
    logic [NUM_VEC-1:0] next_cand;
    logic               fired;

    assign next_cand = cand & match_i;

    // Launch once per task when one candidate is left before the last position.
    assign launch_o = diff_valid && !task_start && !fired &&
                      ($countones(next_cand) == 1) &&
                      (diff_idx < IDX_W'(VEC_LEN - 1));
    assign launch_pos_o = diff_idx + IDX_W'(1);

    // Convert the single remaining candidate into a slot number.
    always_comb begin
        launch_sel_o = '0;
        for (int v = 0; v < NUM_VEC; v++) begin
            if (next_cand[v]) launch_sel_o = SEL_W'(v);
        end
    end

    // Refill candidates at task start, narrow them on every entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand  <= '0;
            fired <= 1'b0;
        end else if (task_start) begin
            cand  <= valid_i;
            fired <= 1'b0;
        end else if (diff_valid) begin
            cand <= next_cand;
            if (launch_o) fired <= 1'b1;
        end
    end

    // R2: without a task start the candidate set only loses members.
    p_cand_narrows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !task_start |=> ((cand & ~$past(cand)) == '0));

    // R10: after a launch no second launch occurs until the next task start.
    p_single_launch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_o && !task_start) |=> !launch_o);
endmodule

// File: rtl/pfp_issue.sv
// Request issuer: walks the positions after the launch point and offers
// previous address plus stored entry, one position per accepted cycle.
// Assumes: prev_rd_addr answers prev_rd_idx combinationally; ADDR_W > DIFF_W.
module pfp_issue #(
    parameter  int unsigned NUM_VEC = pfp_pkg::PFP_NUM_VEC,
    parameter  int unsigned VEC_LEN = pfp_pkg::PFP_VEC_LEN,
    parameter  int unsigned ADDR_W  = pfp_pkg::PFP_ADDR_W,
    parameter  int unsigned DIFF_W  = pfp_pkg::PFP_DIFF_W,
    localparam int unsigned IDX_W   = (VEC_LEN > 1) ? $clog2(VEC_LEN) : 1,
    localparam int unsigned SEL_W   = $clog2(NUM_VEC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              task_start,
    input  logic              task_stop,
    input  logic              launch,
    input  logic [SEL_W-1:0]  launch_sel,
    input  logic [IDX_W-1:0]  launch_pos,
    output logic [SEL_W-1:0]  rd_sel,
    output logic [IDX_W-1:0]  rd_pos,
    input  logic [DIFF_W-1:0] rd_val,
    output logic [IDX_W-1:0]  prev_rd_idx,
    input  logic [ADDR_W-1:0] prev_rd_addr,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [ADDR_W-1:0] pf_addr
);
    import pfp_pkg::*;

    iss_state_e        state;
    logic [IDX_W-1:0]  pos;
    logic [SEL_W-1:0]  sel;
    logic [ADDR_W-1:0] step_ext;
    logic              last;

    assign step_ext    = ADDR_W'($signed(rd_val));
    assign last        = (pos == IDX_W'(VEC_LEN - 1));
    assign rd_sel      = sel;
    assign rd_pos      = pos;
    assign prev_rd_idx = pos;
    assign pf_valid    = (state == ISS_RUN);
    assign pf_addr     = prev_rd_addr + step_ext;

    // Start, advance, finish or abort the walk over the remaining positions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ISS_IDLE;
            pos   <= '0;
            sel   <= '0;
        end else if (task_start || task_stop) begin
            state <= ISS_IDLE;
        end else if (launch) begin
            state <= ISS_RUN;
            pos   <= launch_pos;
            sel   <= launch_sel;
        end else if ((state == ISS_RUN) && pf_ready) begin
            if (last) state <= ISS_IDLE;
            else      pos   <= pos + IDX_W'(1);
        end
    end

    // R5: a stalled request stays offered at the same position.
    p_hold_on_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready && !task_start && !task_stop)
        |=> (pf_valid && $stable(prev_rd_idx)));

    // R7: a task stop leaves nothing offered in the next cycle.
    p_stop_aborts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        task_stop |=> !pf_valid);
endmodule

// File: rtl/pfp_prefix_predictor.sv
// Top: captures the running task's differential, keeps the vector store,
// tracks candidates and issues prefetch addresses for the predicted suffix.
// Assumes: task_start, task_stop and diff_valid are mutually exclusive.
module pfp_prefix_predictor #(
    parameter  int unsigned NUM_VEC = pfp_pkg::PFP_NUM_VEC,
    parameter  int unsigned VEC_LEN = pfp_pkg::PFP_VEC_LEN,
    parameter  int unsigned ADDR_W  = pfp_pkg::PFP_ADDR_W,
    parameter  int unsigned DIFF_W  = pfp_pkg::PFP_DIFF_W,
    localparam int unsigned IDX_W   = (VEC_LEN > 1) ? $clog2(VEC_LEN) : 1,
    localparam int unsigned SEL_W   = $clog2(NUM_VEC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              task_start,
    input  logic              task_stop,
    input  logic              diff_valid,
    input  logic [IDX_W-1:0]  diff_idx,
    input  logic [DIFF_W-1:0] diff_val,
    output logic [IDX_W-1:0]  prev_rd_idx,
    input  logic [ADDR_W-1:0] prev_rd_addr,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [ADDR_W-1:0] pf_addr
);
    logic [VEC_LEN-1:0][DIFF_W-1:0] cur_vec;
    logic [VEC_LEN-1:0]             seen;
    logic [NUM_VEC-1:0]             slot_valid;
    logic [NUM_VEC-1:0]             slot_match;
    logic                           launch;
    logic [SEL_W-1:0]               launch_sel;
    logic [IDX_W-1:0]               launch_pos;
    logic [SEL_W-1:0]               rd_sel;
    logic [IDX_W-1:0]               rd_pos;
    logic [DIFF_W-1:0]              rd_val;

    // Capture the running differential and which positions have arrived.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_vec <= '0;
            seen    <= '0;
        end else if (task_start) begin
            seen <= '0;
        end else if (diff_valid) begin
            cur_vec[diff_idx] <= diff_val;
            seen[diff_idx]    <= 1'b1;
        end
    end

    pfp_vector_store #(.NUM_VEC(NUM_VEC), .VEC_LEN(VEC_LEN), .DIFF_W(DIFF_W)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (task_stop && (&seen)),
        .wr_vec  (cur_vec),
        .cmp_idx (diff_idx),
        .cmp_val (diff_val),
        .valid_o (slot_valid),
        .match_o (slot_match),
        .rd_sel  (rd_sel),
        .rd_pos  (rd_pos),
        .rd_val  (rd_val)
    );

    pfp_match_tracker #(.NUM_VEC(NUM_VEC), .VEC_LEN(VEC_LEN)) i_tracker (
        .clk          (clk),
        .rst_n        (rst_n),
        .task_start   (task_start),
        .diff_valid   (diff_valid),
        .diff_idx     (diff_idx),
        .valid_i      (slot_valid),
        .match_i      (slot_match),
        .launch_o     (launch),
        .launch_sel_o (launch_sel),
        .launch_pos_o (launch_pos)
    );

    pfp_issue #(.NUM_VEC(NUM_VEC), .VEC_LEN(VEC_LEN),
                .ADDR_W(ADDR_W), .DIFF_W(DIFF_W)) i_issue (
        .clk          (clk),
        .rst_n        (rst_n),
        .task_start   (task_start),
        .task_stop    (task_stop),
        .launch       (launch),
        .launch_sel   (launch_sel),
        .launch_pos   (launch_pos),
        .rd_sel       (rd_sel),
        .rd_pos       (rd_pos),
        .rd_val       (rd_val),
        .prev_rd_idx  (prev_rd_idx),
        .prev_rd_addr (prev_rd_addr),
        .pf_valid     (pf_valid),
        .pf_ready     (pf_ready),
        .pf_addr      (pf_addr)
    );

    // R4: a new request stream only begins right after an entry arrived.
    p_issue_follows_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pf_valid) |-> $past(diff_valid));
endmodule

// File: tb/test_pfp_prefix_predictor.sv
// Directed bench: one task per scenario, each checking its own results.
module test_pfp_prefix_predictor;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        task_start, task_stop, diff_valid, pf_ready;
    logic [1:0]  diff_idx;
    logic [15:0] diff_val;
    logic [1:0]  prev_rd_idx;
    logic [31:0] prev_rd_addr;
    logic        pf_valid;
    logic [31:0] pf_addr;

    int n_tests = 0;
    int n_fail  = 0;
    int cap_n   = 0;
    logic [31:0] cap_a [64];
    bit done = 1'b0;

    localparam logic [31:0] BASE = 32'h4000_0000;

    always #5 clk = ~clk;

    // Previous-instance address set: one line apart per position.
    assign prev_rd_addr = BASE + {22'd0, prev_rd_idx, 8'h00};

    pfp_prefix_predictor i_pfp_prefix_predictor (
        .clk(clk), .rst_n(rst_n), .task_start(task_start), .task_stop(task_stop),
        .diff_valid(diff_valid), .diff_idx(diff_idx), .diff_val(diff_val),
        .prev_rd_idx(prev_rd_idx), .prev_rd_addr(prev_rd_addr),
        .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
    );

    // Record every request that the next rising edge will accept.
    always @(negedge clk) begin
        if (rst_n && pf_valid && pf_ready) begin
            if (cap_n < 64) cap_a[cap_n] = pf_addr;
            cap_n = cap_n + 1;
        end
    end

    function automatic logic [31:0] exp_addr(int pos, int d);
        return BASE + 32'(pos * 256) + 32'(d);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; task_start = 1'b0; task_stop = 1'b0; diff_valid = 1'b0;
        diff_idx = '0; diff_val = '0; pf_ready = 1'b1;
        repeat (3) step();
        rst_n = 1'b1;
        cap_n = 0;
    endtask

    task automatic begin_task();
        task_start = 1'b1; step(); task_start = 1'b0;
    endtask

    task automatic end_task();
        task_stop = 1'b1; step(); task_stop = 1'b0;
    endtask

    task automatic send(int idx, int val);
        diff_valid = 1'b1; diff_idx = 2'(idx); diff_val = 16'(val);
        step();
        diff_valid = 1'b0;
    endtask

    task automatic run_vec(int a, int b, int c, int d);
        begin_task();
        send(0, a); send(1, b); send(2, c); send(3, d);
        end_task();
        repeat (2) step();
    endtask

    // R1 and R4: empty store predicts nothing; a stored vector predicts its suffix.
    task automatic t_basic();
        do_reset();
        chk("R1 pf_valid after reset", 32'(pf_valid), 32'd0);
        run_vec(32, 96, 8, 64);
        chk("R1 no request from empty store", 32'(cap_n), 32'd0);
        cap_n = 0;
        run_vec(32, 96, 8, 64);
        chk("R4 request count", 32'(cap_n), 32'd3);
        chk("R4 pos1", cap_a[0], exp_addr(1, 96));
        chk("R4 pos2", cap_a[1], exp_addr(2, 8));
        chk("R4 pos3", cap_a[2], exp_addr(3, 64));
        run_vec(10, -40, -8, 200);
        cap_n = 0;
        run_vec(10, -40, -8, 200);
        chk("R4 negative count", 32'(cap_n), 32'd3);
        chk("R4 negative pos1", cap_a[0], exp_addr(1, -40));
        chk("R4 negative pos2", cap_a[1], exp_addr(2, -8));
    endtask

    // R3 and R10: shared prefixes hold prediction back until unique.
    task automatic t_ambiguous();
        do_reset();
        run_vec(32, 96, 8, 64);
        run_vec(32, 96, 16, -8);
        cap_n = 0;
        begin_task();
        send(0, 32);
        chk("R3 two candidates after pos0", 32'(pf_valid), 32'd0);
        send(1, 96);
        chk("R3 two candidates after pos1", 32'(pf_valid), 32'd0);
        send(2, 8);
        chk("R3 unique at pos2 offers", 32'(pf_valid), 32'd1);
        send(3, 64);
        end_task();
        repeat (2) step();
        chk("R3 single request", 32'(cap_n), 32'd1);
        chk("R3 request address", cap_a[0], exp_addr(3, 64));
        run_vec(5, 6, 7, 9);
        run_vec(5, 6, 7, 11);
        cap_n = 0;
        run_vec(5, 6, 7, 9);
        chk("R10 unique only at last position", 32'(cap_n), 32'd0);
    endtask

    // R6 and R2: a mismatch silences the task; the next start restores candidates.
    task automatic t_nomatch();
        do_reset();
        run_vec(32, 96, 8, 64);
        cap_n = 0;
        begin_task();
        send(0, 33); send(1, 96); send(2, 8); send(3, 64);
        repeat (3) step();
        chk("R6 no request after mismatch", 32'(cap_n), 32'd0);
        end_task();
        repeat (2) step();
        cap_n = 0;
        run_vec(32, 96, 8, 64);
        chk("R2 candidates refilled at start", 32'(cap_n), 32'd3);
    endtask

    // R5: a stall holds the request; acceptance moves one position per cycle.
    task automatic t_stall();
        do_reset();
        run_vec(32, 96, 8, 64);
        cap_n = 0;
        pf_ready = 1'b0;
        begin_task();
        send(0, 32);
        for (int i = 0; i < 3; i++) begin
            chk("R5 held valid", 32'(pf_valid), 32'd1);
            chk("R5 held address", pf_addr, exp_addr(1, 96));
            step();
        end
        chk("R5 nothing accepted while stalled", 32'(cap_n), 32'd0);
        pf_ready = 1'b1;
        step();
        chk("R5 one accepted per cycle", 32'(cap_n), 32'd1);
        step();
        chk("R5 two accepted", 32'(cap_n), 32'd2);
        repeat (3) step();
        chk("R5 total", 32'(cap_n), 32'd3);
        chk("R5 order last", cap_a[2], exp_addr(3, 64));
        end_task();
    endtask

    // R7: stop drops pending requests; a partial vector is not stored.
    task automatic t_abort();
        do_reset();
        run_vec(32, 96, 8, 64);
        cap_n = 0;
        pf_ready = 1'b0;
        begin_task();
        send(0, 32);
        chk("R7 offered before stop", 32'(pf_valid), 32'd1);
        end_task();
        chk("R7 dropped after stop", 32'(pf_valid), 32'd0);
        pf_ready = 1'b1;
        repeat (3) step();
        chk("R7 nothing issued after stop", 32'(cap_n), 32'd0);
    endtask

    // R8: eight slots fill in turn and the ninth vector replaces the oldest.
    task automatic probe(int e0, output int n);
        cap_n = 0;
        begin_task();
        send(0, e0);
        repeat (4) step();
        end_task();
        n = cap_n;
    endtask

    task automatic t_fifo();
        int n;
        do_reset();
        for (int k = 0; k < 8; k++) run_vec(k * 4 + 1, k + 1, k + 2, k + 3);
        run_vec(100, 1, 2, 3);
        probe(1, n);
        chk("R8 oldest slot replaced", 32'(n), 32'd0);
        probe(5, n);
        chk("R8 second slot kept", 32'(n), 32'd3);
        chk("R8 second slot pos1", cap_a[0], exp_addr(1, 2));
        chk("R8 second slot pos3", cap_a[2], exp_addr(3, 4));
        probe(100, n);
        chk("R8 newest vector", 32'(n), 32'd3);
        chk("R8 newest pos2", cap_a[1], exp_addr(2, 2));
    endtask

    // R9: a repeated vector takes no second slot, so its prefix stays unique.
    task automatic t_dup();
        do_reset();
        run_vec(32, 96, 8, 64);
        run_vec(32, 96, 8, 64);
        cap_n = 0;
        run_vec(32, 96, 8, 64);
        chk("R9 duplicate not stored", 32'(cap_n), 32'd3);
    endtask

    initial begin
        t_basic();
        t_ambiguous();
        t_nomatch();
        t_stall();
        t_abort();
        t_fifo();
        t_dup();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule